// File: doc/BRIEF.md
# Dual-Pattern Overlapping Sequence Detector

This block watches a one-bit serial stream and flags, on the same clock as the completing bit, every point where the stream seen so far ends in either of two patterns. The first pattern is four bits long: zero, zero, one, one, in arrival order. The second is three bits long: one, one, zero. Both patterns are tracked at once, and they may share bits. Any bit can end one match and also start or continue another, so the detector never falls back to its start state just because it fired.

Internally the block is a six-state Mealy machine. Its state records the longest recent tail of the stream that could still grow into one of the two patterns. The flag is a combinational function of that state and the present input bit, so it answers within the same cycle. A synchronous, active-low reset clears the history. Bits taken in before a reset never count toward a later match.

Top module: `seqdet_dual`

## Requirements
- R1: On the first clock edge where `rst_n` is low, the machine enters its start state with an empty history. The first bit after reset leaves `z_out` at 0, whatever its value.
- R2: `z_out` is 1 during any cycle whose bit `x_in` ends the accepted stream with 0,0,1,1 (oldest first).
- R3: `z_out` is 1 during any cycle whose bit `x_in` ends the accepted stream with 1,1,0 (oldest first).
- R4: `z_out` is 0 in every cycle where neither R2 nor R3 applies.
- R5: A match does not restart detection. In 0,0,1,1,0, `z_out` is 1 on both the fourth and fifth bits. In 1,1,0,0,1,1, it is 1 on the third and sixth bits.
- R6: `z_out` stays 0 until at least three bits have been accepted since reset. Bits accepted before a reset never help complete a later match.
- R7: `z_out` is a Mealy output. It follows a change of `x_in` within the same cycle, with no clock edge between them.
- R8: Reset is synchronous. Pulling `rst_n` low in the middle of a stream discards any partial match at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one input bit is accepted per edge |
| rst_n | input | 1 | Synchronous active-low reset to the start state |
| x_in | input | 1 | Serial input bit for the current cycle |
| z_out | output | 1 | Match flag for the current cycle's bit (Mealy) |

## Verification
The bench goes after overlap first. A design that returned to its start state after firing would miss the back-to-back hits in 0,0,1,1,0 and the second hit in 1,1,0,0,1,1. It also checks start-up and mid-stream resets. A model that simply shifted bits into a zero-filled register would report 0,0,1,1 after only two ones following reset, and a lost reset would let a stale 0,0,1 finish a match. Same-cycle changes of `x_in` catch an output that was registered, or that ignored the input. Long biased random runs, with occasional resets, cover wrong transitions out of the shared-suffix states such as "001" and "11".

// File: rtl/det_pkg.sv
// det_pkg: shared state type for the dual-pattern detector.
// Each state names the longest tail of the input stream that is still a
// prefix of 0011 or of 110 (oldest bit first).
package det_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,  // empty history
        ST_Z    = 3'd1,  // tail "0"
        ST_ZZ   = 3'd2,  // tail "00"
        ST_ZZO  = 3'd3,  // tail "001"
        ST_O    = 3'd4,  // tail "1"
        ST_OO   = 3'd5   // tail "11"
    } det_state_t;

endpackage

// File: rtl/det_state_reg.sv
// det_state_reg: holds the detector state.
// Assumes: rst_n is synchronous and active-low; an illegal code (never
// reached in normal use) is flushed to the start state on the next edge
// by the next-state logic.
module det_state_reg
    import det_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  det_state_t state_d,
    output det_state_t state_q
);

    // Purpose: load the next state, or the start state while in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/det_next_state.sv
// det_next_state: longest-suffix transition function for 0011 and 110.
// Assumes: state_q encodes the tail described in det_pkg; the new tail is
// the longest suffix of (tail, x_in) that is a prefix of either pattern.
module det_next_state
    import det_pkg::*;
(
    input  det_state_t state_q,
    input  logic       x_in,
    output det_state_t state_d
);

    // Purpose: pick the next tail state from the current tail and bit.
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: state_d = x_in ? ST_O   : ST_Z;
            ST_Z:    state_d = x_in ? ST_O   : ST_ZZ;   // "01" keeps "1"
            ST_ZZ:   state_d = x_in ? ST_ZZO : ST_ZZ;   // "000" keeps "00"
            ST_ZZO:  state_d = x_in ? ST_OO  : ST_Z;    // "0011" keeps "11"
            ST_O:    state_d = x_in ? ST_OO  : ST_Z;    // "10" keeps "0"
            ST_OO:   state_d = x_in ? ST_OO  : ST_Z;    // "110" keeps "0"
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/det_mealy_out.sv
// det_mealy_out: match flag for the current bit.
// Assumes: the flag is combinational in state and input (Mealy), so a
// consumer samples it before the edge that accepts the bit.
module det_mealy_out
    import det_pkg::*;
(
    input  det_state_t state_q,
    input  logic       x_in,
    output logic       z_out
);

    logic hit_long;   // tail "001" completed by a 1
    logic hit_short;  // tail "11" completed by a 0

    // Purpose: decode each pattern's completing condition.
    always_comb begin
        hit_long  = (state_q == ST_ZZO) &&  x_in;
        hit_short = (state_q == ST_OO)  && !x_in;
    end

    // Purpose: merge both pattern hits into the single flag.
    always_comb begin
        z_out = hit_long || hit_short;
    end

endmodule

// File: rtl/seqdet_dual.sv
// seqdet_dual: overlapping detector for the serial patterns 0011 and 110.
// Assumes: one bit per rising edge; synchronous active-low reset; z_out is
// valid for the bit presented in the current cycle.
module seqdet_dual
    import det_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic x_in,
    output logic z_out
);

    det_state_t state_q;
    det_state_t state_d;

    det_state_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_d (state_d),
        .state_q (state_q)
    );

    det_next_state u_next (
        .state_q (state_q),
        .x_in    (x_in),
        .state_d (state_d)
    );

    det_mealy_out u_out (
        .state_q (state_q),
        .x_in    (x_in),
        .z_out   (z_out)
    );

endmodule

// File: rtl/seqdet_dual_chk.sv
// seqdet_dual_chk: property checker bound to seqdet_dual.
// Assumes: one bit is accepted on each edge where rst_n is high.
module seqdet_dual_chk
    import det_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       x_in,
    input  logic       z_out,
    input  det_state_t state_q
);

    logic [2:0] seen;  // bits accepted since reset, saturating at 4

    // Purpose: count accepted bits so history checks stay inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= 3'd0;
        end else if (seen != 3'd4) begin
            seen <= seen + 3'd1;
        end
    end

    // R1: leaving reset finds the start state.
    p_start_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (state_q == ST_IDLE));

    // R2: 0,0,1,1 must fire.
    p_hit_long_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 3'd3 && x_in && $past(x_in) && !$past(x_in, 2) && !$past(x_in, 3))
        |-> z_out);

    // R3: 1,1,0 must fire.
    p_hit_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 3'd2 && !x_in && $past(x_in) && $past(x_in, 2)) |-> z_out);

    // R4: no flag without one of the two patterns.
    p_no_false_r4: assert property (@(posedge clk) disable iff (!rst_n)
        z_out |-> ((seen >= 3'd3 && x_in && $past(x_in) && !$past(x_in, 2) && !$past(x_in, 3))
                || (seen >= 3'd2 && !x_in && $past(x_in) && $past(x_in, 2))));

    // R6: quiet until three bits have arrived.
    p_quiet_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen < 3'd2) |-> !z_out);

endmodule

bind seqdet_dual seqdet_dual_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .x_in    (x_in),
    .z_out   (z_out),
    .state_q (state_q)
);

// File: tb/seqdet_dual_tb_top.sv
`timescale 1ns/1ps
// seqdet_dual_tb_top: directed and seeded random checks against a
// history-based model (last four accepted bits plus a bit count).
module seqdet_dual_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic x_in = 1'b0;
    logic z_out;

    int   n_cmp = 0;
    int   n_bad = 0;
    logic [3:0] hist = 4'd0;  // bit 0 newest
    int   cnt = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    seqdet_dual dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .x_in  (x_in),
        .z_out (z_out)
    );

    // Expected flag for bit b given the accepted history.
    function automatic logic exp_z(input logic [3:0] h, input int c, input logic b);
        logic [3:0] nh;
        nh = {h[2:0], b};
        return ((c + 1 >= 4) && (nh == 4'b0011)) || ((c + 1 >= 3) && (nh[2:0] == 3'b110));
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: z_out=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Starts and ends at posedge+1; the edge at the end accepts b.
    task automatic step(input logic b, input string req);
        x_in = b;
        @(negedge clk);
        check(z_out, exp_z(hist, cnt, b), req);
        hist = {hist[2:0], b};
        if (cnt < 4) cnt++;
        @(posedge clk); #1;
    endtask

    task automatic feed(input logic [7:0] bits, input int n, input string req);
        for (int i = n - 1; i >= 0; i--) step(bits[i], req);
    endtask

    task automatic do_reset(input int n);
        rst_n = 1'b0;
        repeat (n) @(posedge clk);
        #1;
        rst_n = 1'b1;
        hist = 4'd0;
        cnt = 0;
    endtask

    initial begin
        void'($urandom(32'h5EED_0110));
        @(posedge clk); #1;
        do_reset(2);

        // R1: first bit after reset never flags.
        step(1'b1, "R1");
        do_reset(1);
        step(1'b0, "R1");

        // R6: zero-filled history must not fake 0011.
        do_reset(1);
        feed(8'b0000_0011, 2, "R6");
        step(1'b0, "R3");

        // R2: plain long pattern.
        do_reset(1);
        feed(8'b0000_0011, 4, "R2");

        // R3: plain short pattern after a run of ones.
        do_reset(1);
        feed(8'b0000_1110, 4, "R3");

        // R5: back-to-back and chained overlaps.
        do_reset(1);
        feed(8'b0000_0110, 5, "R5");
        do_reset(1);
        feed(8'b0011_0011, 6, "R5");

        // R7: flag follows x_in inside one cycle.
        do_reset(1);
        feed(8'b0000_0001, 3, "R7");
        x_in = 1'b1;
        @(negedge clk);
        check(z_out, 1'b1, "R7");
        #1 x_in = 1'b0;
        #1 check(z_out, 1'b0, "R7");
        hist = {hist[2:0], 1'b0};
        cnt++;
        @(posedge clk); #1;

        // R8: reset mid-stream drops partial matches.
        do_reset(1);
        feed(8'b0000_0001, 3, "R8");
        do_reset(1);
        step(1'b1, "R8");
        feed(8'b0000_0011, 2, "R8");
        do_reset(1);
        step(1'b0, "R8");

        // R4: biased random stream with sparse resets.
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 250 == 0) begin
                do_reset(1 + ($urandom % 3));
            end else begin
                step(($urandom % 5) < 2 ? 1'b0 : 1'b1, "R4");
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run incomplete, expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule